// File: doc/BRIEF.md
# Triggered Probe Capture Engine

This block records a group of on-chip probe signals into a circular sample memory so that a host can later inspect what happened around an event of interest. Once armed by a start command, it first records a programmable number of samples ahead of any trigger. It then keeps recording in a ring while it watches a compare unit. That unit tests one selected probe against a programmable value or against its own previous value. When the compare fires, recording continues until the memory holds exactly one full window, and the engine then freezes. The trigger sample sits at the programmed pre-trigger distance from the oldest sample.

Every setting, every status value and every stored sample is reached through one simple register bus. A request is an address, write data, a read/write flag and a one-cycle valid. Read answers return on a data output with its own valid flag. Configuration writes land in staging registers. They only reach the capture logic when the staging group's strobe register goes from 0 to 1, so a multi-field update takes effect in a single cycle. Start and stop are commands carried by that same staged mechanism. The engine acts on the rising edge of their active copies.

Top module: `trig_capture`

## Requirements
- R1: After synchronous reset, the state register (address 0x001) reads 0 (idle), the response valid output is low, and both pointer registers read 0.
- R2: Every read request (valid high, rw low) is answered exactly two clock edges later with `rsp_valid` high for one cycle. The data is the value the addressed location held just before the request edge. A write request (rw high) produces no response.
- R3: A read of any address outside the map (map: 0x000-0x007, 0x010-0x013, and sample memory 0x400-0x7FF for the default depth of 1024) returns zero with `rsp_valid` still asserted.
- R4: Writes to 0x002 (pre-trigger count), 0x003 (mode), 0x004 (start) and 0x005 (stop) only reach the capture logic when 0x000 is written with bit 0 = 1 while it holds 0. Writes to 0x011 (operation), 0x012 (argument) and 0x013 (probe select) behave the same way with strobe 0x010. Staged values read back directly.
- R5: A rising edge of the active start bit moves the engine from idle (0) to filling (1), or to armed (2) when the pre-trigger count is 0. Start has no effect in other states. A rising edge of the active stop bit returns the engine to idle from any state, and stop wins over start.
- R6: In the filling state, one sample is written per cycle and the compare result is ignored. The engine moves to armed once exactly pre-trigger-count samples are written.
- R7: The operation codes are 0 never, 1 value greater than previous cycle, 2 value less than previous, 3 value changed, 4 greater than argument, 5 less than, 6 greater or equal, 7 less or equal, 8 equal, 9 not equal; codes 10-15 never fire. Select 0, 1 and 2 pick the 1-bit, 3-bit and 9-bit probe, and select 3 compares a constant zero.
- R8: In armed, a firing compare writes the trigger sample and enters capturing (3). After DEPTH minus pre-trigger-count samples in total, counting the trigger sample, the engine enters done (4) and stays there until stop.
- R9: On the trigger, the read pointer (0x006) becomes the trigger sample's address minus the pre-trigger count, modulo DEPTH. The write pointer (0x007) is the next address to be written and starts at 0 on each start.
- R10: With mode bit 0 set to 1, the engine treats the compare as firing in its first armed cycle.
- R11: Writes to the read-only addresses 0x001, 0x006 and 0x007, to sample memory and to unmapped addresses change nothing.
- R12: Address 0x400+i returns sample i packed with the 1-bit probe in bit 0, the 3-bit probe in bits 3:1 and the 9-bit probe in bits 12:4, zero above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Request address |
| bus_wdata | input | 16 | Request write data |
| bus_rw | input | 1 | 1 = write, 0 = read |
| bus_valid | input | 1 | Request present this cycle |
| rsp_data | output | 16 | Read answer data |
| rsp_valid | output | 1 | Read answer present this cycle |
| probe_a | input | 1 | 1-bit probe |
| probe_b | input | 3 | 3-bit probe |
| probe_c | input | 9 | 9-bit probe |

## Verification
The assertions take for granted that each request is a single-cycle valid pulse with rw held for that cycle. They also assume that reset is applied synchronously for several cycles before any traffic. The bus has no back-pressure, so no response can be refused, and the latency property depends only on the request pulse. The stimulus changes every input on the falling clock edge and leaves an idle cycle after each request. Start and stop are issued only through full strobe sequences, so the active command bits rise and fall cleanly.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_CAPT  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_t;

  typedef enum logic [3:0] {
    OP_NEVER = 4'd0,
    OP_UP    = 4'd1,
    OP_DOWN  = 4'd2,
    OP_DIFF  = 4'd3,
    OP_GT    = 4'd4,
    OP_LT    = 4'd5,
    OP_GE    = 4'd6,
    OP_LE    = 4'd7,
    OP_EQ    = 4'd8,
    OP_NE    = 4'd9
  } trig_op_t;

  // control group
  localparam int unsigned A_CTL_STB = 0;
  localparam int unsigned A_STATE   = 1;
  localparam int unsigned A_PRECNT  = 2;
  localparam int unsigned A_MODE    = 3;
  localparam int unsigned A_START   = 4;
  localparam int unsigned A_STOP    = 5;
  localparam int unsigned A_RDPTR   = 6;
  localparam int unsigned A_WRPTR   = 7;
  // compare group
  localparam int unsigned A_CMP_STB = 16;
  localparam int unsigned A_OP      = 17;
  localparam int unsigned A_ARG     = 18;
  localparam int unsigned A_SEL     = 19;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LOC_W  = 10,
  parameter int unsigned ARG_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctl_stb,
  output logic              cmp_stb,
  output logic [LOC_W-1:0]  stg_loc,
  output logic              stg_mode,
  output logic              stg_start,
  output logic              stg_stop,
  output logic [3:0]        stg_op,
  output logic [ARG_W-1:0]  stg_arg,
  output logic [1:0]        stg_sel,
  output logic [LOC_W-1:0]  act_loc,
  output logic              act_mode,
  output logic              act_start,
  output logic              act_stop,
  output logic [3:0]        act_op,
  output logic [ARG_W-1:0]  act_arg,
  output logic [1:0]        act_sel
);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  logic ctl_rise, cmp_rise;
  assign ctl_rise = wr_en && (addr == ADDR_W'(A_CTL_STB)) && wdata[0] && !ctl_stb;
  assign cmp_rise = wr_en && (addr == ADDR_W'(A_CMP_STB)) && wdata[0] && !cmp_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_stb   <= 1'b0;
      cmp_stb   <= 1'b0;
      stg_loc   <= '0;
      stg_mode  <= 1'b0;
      stg_start <= 1'b0;
      stg_stop  <= 1'b0;
      stg_op    <= '0;
      stg_arg   <= '0;
      stg_sel   <= '0;
      act_loc   <= '0;
      act_mode  <= 1'b0;
      act_start <= 1'b0;
      act_stop  <= 1'b0;
      act_op    <= '0;
      act_arg   <= '0;
      act_sel   <= '0;
    end else begin
      if (ctl_rise) begin
        act_loc   <= stg_loc;
        act_mode  <= stg_mode;
        act_start <= stg_start;
        act_stop  <= stg_stop;
      end
      if (cmp_rise) begin
        act_op  <= stg_op;
        act_arg <= stg_arg;
        act_sel <= stg_sel;
      end
      if (wr_en) begin
        case (addr)
          ADDR_W'(A_CTL_STB): ctl_stb   <= wdata[0];
          ADDR_W'(A_PRECNT):  stg_loc   <= wdata[LOC_W-1:0];
          ADDR_W'(A_MODE):    stg_mode  <= wdata[0];
          ADDR_W'(A_START):   stg_start <= wdata[0];
          ADDR_W'(A_STOP):    stg_stop  <= wdata[0];
          ADDR_W'(A_CMP_STB): cmp_stb   <= wdata[0];
          ADDR_W'(A_OP):      stg_op    <= wdata[3:0];
          ADDR_W'(A_ARG):     stg_arg   <= wdata[ARG_W-1:0];
          ADDR_W'(A_SEL):     stg_sel   <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  // R4: active control copy only moves on a strobe 0->1 write
  p_cfg_held_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(A_CTL_STB) && wdata[0] && !ctl_stb)
      |=> ($stable(act_loc) && $stable(act_start) && $stable(act_stop)));

  p_cmp_held_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(A_CMP_STB) && wdata[0] && !cmp_stb)
      |=> ($stable(act_op) && $stable(act_arg) && $stable(act_sel)));

endmodule

// File: rtl/tcap_trigger.sv
module tcap_trigger
  import tcap_pkg::*;
#(
  parameter int unsigned PA_W  = 1,
  parameter int unsigned PB_W  = 3,
  parameter int unsigned PC_W  = 9,
  parameter int unsigned ARG_W = 9,
  localparam int unsigned SMP_W = PA_W + PB_W + PC_W
) (
  input  logic [SMP_W-1:0] smp_now,
  input  logic [SMP_W-1:0] smp_prev,
  input  logic [1:0]       sel,
  input  logic [3:0]       op,
  input  logic [ARG_W-1:0] arg,
  output logic             hit
);

  localparam int unsigned NPROBE = 3;
  localparam int unsigned WIDTHS [NPROBE] = '{PA_W, PB_W, PC_W};
  localparam int unsigned OFFS   [NPROBE] = '{0, PA_W, PA_W + PB_W};

  logic [ARG_W-1:0] fld_now  [4];
  logic [ARG_W-1:0] fld_prev [4];

  for (genvar g = 0; g < NPROBE; g++) begin : g_field
    assign fld_now[g]  = ARG_W'(smp_now[OFFS[g] +: WIDTHS[g]]);
    assign fld_prev[g] = ARG_W'(smp_prev[OFFS[g] +: WIDTHS[g]]);
  end
  assign fld_now[3]  = '0;
  assign fld_prev[3] = '0;

  logic [ARG_W-1:0] cur, old;
  assign cur = fld_now[sel];
  assign old = fld_prev[sel];

  always_comb begin
    case (trig_op_t'(op))
      OP_UP:   hit = cur > old;
      OP_DOWN: hit = cur < old;
      OP_DIFF: hit = cur != old;
      OP_GT:   hit = cur > arg;
      OP_LT:   hit = cur < arg;
      OP_GE:   hit = cur >= arg;
      OP_LE:   hit = cur <= arg;
      OP_EQ:   hit = cur == arg;
      OP_NE:   hit = cur != arg;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/tcap_fsm.sv
module tcap_fsm
  import tcap_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned LOC_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = LOC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pulse,
  input  logic             stop_pulse,
  input  logic             hit,
  input  logic             immediate,
  input  logic [LOC_W-1:0] pre_cnt,
  output cap_state_t       state,
  output logic [LOC_W-1:0] wptr,
  output logic [LOC_W-1:0] rptr,
  output logic             we
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] post;
  logic [CNT_W-1:0] cnt_nx;

  assign post   = CNT_W'(DEPTH) - CNT_W'(pre_cnt);
  assign cnt_nx = cnt + CNT_W'(1);
  assign we     = (state == ST_FILL) || (state == ST_ARMED) || (state == ST_CAPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
    end else if (stop_pulse) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start_pulse) begin
          wptr  <= '0;
          rptr  <= '0;
          cnt   <= '0;
          state <= (pre_cnt == '0) ? ST_ARMED : ST_FILL;
        end
        ST_FILL: begin
          wptr <= wptr + LOC_W'(1);
          cnt  <= cnt_nx;
          if (cnt_nx == CNT_W'(pre_cnt)) state <= ST_ARMED;
        end
        ST_ARMED: begin
          wptr <= wptr + LOC_W'(1);
          if (hit || immediate) begin
            rptr  <= wptr - pre_cnt;
            cnt   <= CNT_W'(1);
            state <= (post == CNT_W'(1)) ? ST_DONE : ST_CAPT;
          end
        end
        ST_CAPT: begin
          wptr <= wptr + LOC_W'(1);
          cnt  <= cnt_nx;
          if (cnt_nx == post) state <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  p_stop_idle_r5: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> (state == ST_IDLE));

  p_fill_no_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |=> (state != ST_CAPT && state != ST_DONE));

  p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !stop_pulse) |=> (state == ST_DONE));

  p_idle_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start_pulse) |=> $stable(wptr));

endmodule

// File: rtl/tcap_mem.sv
module tcap_mem #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 13,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
    if (we) store[waddr] <= wdata;
  end

endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import tcap_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned PA_W   = 1,
  parameter int unsigned PB_W   = 3,
  parameter int unsigned PC_W   = 9,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rw,
  input  logic              bus_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid,
  input  logic [PA_W-1:0]   probe_a,
  input  logic [PB_W-1:0]   probe_b,
  input  logic [PC_W-1:0]   probe_c
);

  localparam int unsigned LOC_W = $clog2(DEPTH);
  localparam int unsigned SMP_W = PA_W + PB_W + PC_W;
  localparam int unsigned ARG_W = max3(PA_W, PB_W, PC_W);
  localparam logic [ADDR_W:0] MEM_LO = (ADDR_W + 1)'(DEPTH);
  localparam logic [ADDR_W:0] MEM_HI = (ADDR_W + 1)'(2 * DEPTH);

  logic [SMP_W-1:0] smp_now, smp_prev;
  assign smp_now = {probe_c, probe_b, probe_a};

  always_ff @(posedge clk) begin
    if (rst) smp_prev <= '0;
    else     smp_prev <= smp_now;
  end

  logic              ctl_stb, cmp_stb;
  logic [LOC_W-1:0]  stg_loc, act_loc;
  logic              stg_mode, stg_start, stg_stop;
  logic              act_mode, act_start, act_stop;
  logic [3:0]        stg_op, act_op;
  logic [ARG_W-1:0]  stg_arg, act_arg;
  logic [1:0]        stg_sel, act_sel;

  tcap_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOC_W(LOC_W), .ARG_W(ARG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_valid && bus_rw), .addr(bus_addr), .wdata(bus_wdata),
    .ctl_stb(ctl_stb), .cmp_stb(cmp_stb),
    .stg_loc(stg_loc), .stg_mode(stg_mode), .stg_start(stg_start), .stg_stop(stg_stop),
    .stg_op(stg_op), .stg_arg(stg_arg), .stg_sel(stg_sel),
    .act_loc(act_loc), .act_mode(act_mode), .act_start(act_start), .act_stop(act_stop),
    .act_op(act_op), .act_arg(act_arg), .act_sel(act_sel)
  );

  logic start_d, stop_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      start_d <= 1'b0;
      stop_d  <= 1'b0;
    end else begin
      start_d <= act_start;
      stop_d  <= act_stop;
    end
  end

  logic hit;
  tcap_trigger #(.PA_W(PA_W), .PB_W(PB_W), .PC_W(PC_W), .ARG_W(ARG_W)) u_trig (
    .smp_now(smp_now), .smp_prev(smp_prev), .sel(act_sel), .op(act_op),
    .arg(act_arg), .hit(hit)
  );

  cap_state_t       state;
  logic [LOC_W-1:0] wptr, rptr;
  logic             we;

  tcap_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst(rst),
    .start_pulse(act_start && !start_d), .stop_pulse(act_stop && !stop_d),
    .hit(hit), .immediate(act_mode), .pre_cnt(act_loc),
    .state(state), .wptr(wptr), .rptr(rptr), .we(we)
  );

  logic [SMP_W-1:0] mem_q;
  tcap_mem #(.DEPTH(DEPTH), .WIDTH(SMP_W)) u_mem (
    .clk(clk), .we(we), .waddr(wptr), .wdata(smp_now),
    .raddr(bus_addr[LOC_W-1:0]), .rdata(mem_q)
  );

  // readback: stage 1 latches register value and memory word, stage 2 presents
  logic              is_mem;
  logic [DATA_W-1:0] reg_val;
  assign is_mem = ({1'b0, bus_addr} >= MEM_LO) && ({1'b0, bus_addr} < MEM_HI);

  always_comb begin
    case (bus_addr)
      ADDR_W'(A_CTL_STB): reg_val = DATA_W'(ctl_stb);
      ADDR_W'(A_STATE):   reg_val = DATA_W'(state);
      ADDR_W'(A_PRECNT):  reg_val = DATA_W'(stg_loc);
      ADDR_W'(A_MODE):    reg_val = DATA_W'(stg_mode);
      ADDR_W'(A_START):   reg_val = DATA_W'(stg_start);
      ADDR_W'(A_STOP):    reg_val = DATA_W'(stg_stop);
      ADDR_W'(A_RDPTR):   reg_val = DATA_W'(rptr);
      ADDR_W'(A_WRPTR):   reg_val = DATA_W'(wptr);
      ADDR_W'(A_CMP_STB): reg_val = DATA_W'(cmp_stb);
      ADDR_W'(A_OP):      reg_val = DATA_W'(stg_op);
      ADDR_W'(A_ARG):     reg_val = DATA_W'(stg_arg);
      ADDR_W'(A_SEL):     reg_val = DATA_W'(stg_sel);
      default:            reg_val = '0;
    endcase
  end

  logic              s1_valid, s1_mem;
  logic [DATA_W-1:0] s1_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_mem    <= 1'b0;
      s1_val    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      s1_valid  <= bus_valid && !bus_rw;
      s1_mem    <= is_mem;
      s1_val    <= reg_val;
      rsp_valid <= s1_valid;
      rsp_data  <= s1_mem ? DATA_W'(mem_q) : s1_val;
    end
  end

  p_read_answered_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_rw) |=> ##1 rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_valid && !bus_rw, 2));

  p_rsp_single_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(bus_valid && !bus_rw)) |=> !rsp_valid);

endmodule

// File: tb/sim_trig_capture.sv
module sim_trig_capture;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rw = 1'b0;
  logic        bus_valid = 1'b0;
  logic [15:0] rsp_data;
  logic        rsp_valid;
  logic [0:0]  probe_a = '0;
  logic [2:0]  probe_b = '0;
  logic [8:0]  probe_c = '0;

  always #5 clk = ~clk;

  trig_capture u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rw(bus_rw),
    .bus_valid(bus_valid), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
    .probe_a(probe_a), .probe_b(probe_b), .probe_c(probe_c)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string cur_tag = "R2";

  // free-running probes a and c; probe b is steered by the scenario
  always @(negedge clk) begin
    probe_c <= probe_c + 9'd3;
    probe_a <= ~probe_a;
  end

  // ---------------- behavioural reference ----------------
  int m_state, m_wp, m_rp, m_cnt;
  int c_stb, k_stb, s_loc, s_mode, s_start, s_stop, s_op, s_arg, s_sel;
  int a_loc, a_mode, a_start, a_stop, a_op, a_arg, a_sel;
  int start_d, stop_d;
  int m_prev;
  int m_mem [1024];
  bit e1v, e2v;
  int e1d, e2d;
  string e1t, e2t;

  function automatic int field(input int smp, input int sel);
    case (sel)
      0: return smp & 1;
      1: return (smp >> 1) & 7;
      2: return (smp >> 4) & 511;
      default: return 0;
    endcase
  endfunction

  function automatic bit fires(input int now, input int prv);
    int c, p;
    c = field(now, a_sel);
    p = field(prv, a_sel);
    case (a_op)
      1: return c > p;
      2: return c < p;
      3: return c != p;
      4: return c > a_arg;
      5: return c < a_arg;
      6: return c >= a_arg;
      7: return c <= a_arg;
      8: return c == a_arg;
      9: return c != a_arg;
      default: return 0;
    endcase
  endfunction

  function automatic int peek(input int a);
    case (a)
      0: return c_stb;
      1: return m_state;
      2: return s_loc;
      3: return s_mode;
      4: return s_start;
      5: return s_stop;
      6: return m_rp;
      7: return m_wp;
      16: return k_stb;
      17: return s_op;
      18: return s_arg;
      19: return s_sel;
      default: return (a >= 1024 && a < 2048) ? m_mem[a - 1024] : 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_wp = 0; m_rp = 0; m_cnt = 0;
      c_stb = 0; k_stb = 0; s_loc = 0; s_mode = 0; s_start = 0; s_stop = 0;
      s_op = 0; s_arg = 0; s_sel = 0;
      a_loc = 0; a_mode = 0; a_start = 0; a_stop = 0; a_op = 0; a_arg = 0; a_sel = 0;
      start_d = 0; stop_d = 0; m_prev = 0;
      e1v = 0; e2v = 0; e1d = 0; e2d = 0;
    end else begin
      int smp, wd, ad;
      bit go, halt, h;
      e2v = e1v; e2d = e1d; e2t = e1t;
      e1v = bus_valid && !bus_rw;
      if (e1v) begin e1d = peek(int'(bus_addr)); e1t = cur_tag; end
      go = a_start && !start_d;
      halt = a_stop && !stop_d;
      start_d = a_start; stop_d = a_stop;
      smp = int'({probe_c, probe_b, probe_a});
      h = fires(smp, m_prev);
      if (halt) m_state = 0;
      else begin
        case (m_state)
          0: if (go) begin
               m_wp = 0; m_rp = 0; m_cnt = 0;
               m_state = (a_loc == 0) ? 2 : 1;
             end
          1: begin
               m_mem[m_wp] = smp; m_wp = (m_wp + 1) % 1024; m_cnt++;
               if (m_cnt == a_loc) m_state = 2;
             end
          2: begin
               m_mem[m_wp] = smp;
               if (h || a_mode != 0) begin
                 m_rp = (m_wp - a_loc + 1024) % 1024;
                 m_cnt = 1;
                 m_state = (1024 - a_loc == 1) ? 4 : 3;
               end
               m_wp = (m_wp + 1) % 1024;
             end
          3: begin
               m_mem[m_wp] = smp; m_wp = (m_wp + 1) % 1024; m_cnt++;
               if (m_cnt == 1024 - a_loc) m_state = 4;
             end
          default: ;
        endcase
      end
      m_prev = smp;
      if (bus_valid && bus_rw) begin
        wd = int'(bus_wdata); ad = int'(bus_addr);
        case (ad)
          0: begin
               if ((wd & 1) != 0 && c_stb == 0) begin
                 a_loc = s_loc; a_mode = s_mode; a_start = s_start; a_stop = s_stop;
               end
               c_stb = wd & 1;
             end
          2: s_loc = wd & 1023;
          3: s_mode = wd & 1;
          4: s_start = wd & 1;
          5: s_stop = wd & 1;
          16: begin
                if ((wd & 1) != 0 && k_stb == 0) begin
                  a_op = s_op; a_arg = s_arg; a_sel = s_sel;
                end
                k_stb = wd & 1;
              end
          17: s_op = wd & 15;
          18: s_arg = wd & 511;
          19: s_sel = wd & 3;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison of the bus answer against the reference
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (rsp_valid !== e2v) begin
        failures++;
        $display("FAIL R2 rsp_valid actual=%0b expected=%0b", rsp_valid, e2v);
      end
      if (e2v) begin
        checks++;
        if (rsp_data !== 16'(e2d)) begin
          failures++;
          $display("FAIL %s rsp_data actual=%h expected=%h", e2t, rsp_data, 16'(e2d));
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 16'(a); bus_wdata = 16'(d); bus_rw = 1'b1; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_rw = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string tag);
    cur_tag = tag;
    bus_addr = 16'(a); bus_rw = 1'b0; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic stage(input int base, input int a, input int d);
    wr(base, 0); wr(a, d); wr(base, 1); wr(base, 0);
  endtask

  task automatic pulse(input int a);
    stage(0, a, 1);
    stage(0, a, 0);
  endtask

  task automatic arm(input int op, input int arg, input int sel, input int loc, input int mode);
    pulse(5);
    stage(16, 17, op); stage(16, 18, arg); stage(16, 19, sel);
    stage(0, 2, loc); stage(0, 3, mode);
    pulse(4);
  endtask

  initial begin
    ticks(5);
    rst = 1'b0;
    ticks(2);

    // R1 reset values, R3 unmapped reads
    rd(1, "R1"); rd(6, "R1"); rd(7, "R1");
    rd(16'h0050, "R3"); rd(16'hFFFF, "R3"); rd(16'h0008, "R3");

    // R11 read-only and unmapped writes ignored
    wr(1, 3); wr(6, 99); wr(7, 55); wr(16'h0405, 7); wr(16'h0030, 1);
    rd(1, "R11"); rd(6, "R11"); rd(7, "R11"); rd(16'h0030, "R11");

    // R4 staged start without strobe has no effect
    wr(4, 1); ticks(5); rd(1, "R4"); rd(4, "R4");
    wr(4, 0);

    // main capture: probe b equal to 4, 511 pre-trigger samples
    probe_b = 3'd0;
    arm(8, 4, 1, 511, 0);
    ticks(50); rd(1, "R5");
    probe_b = 3'd4; ticks(4); probe_b = 3'd0;   // R6: ignored while filling
    rd(1, "R6"); rd(7, "R6");
    ticks(600); rd(1, "R5"); rd(2, "R4"); rd(17, "R4");
    probe_b = 3'd4; ticks(3); probe_b = 3'd1;
    rd(1, "R8"); rd(6, "R9");
    ticks(600);
    rd(1, "R8"); rd(6, "R9"); rd(7, "R9");
    for (int i = 0; i < 1024; i++) rd(1024 + i, "R12");
    pulse(4); rd(1, "R5");   // start ignored in done

    // R5 stop from filling
    arm(0, 0, 1, 300, 0);
    ticks(40); rd(1, "R5");
    pulse(5); rd(1, "R5");

    // R7 each operation code on probe b, no pre-trigger window
    for (int op = 0; op < 12; op++) begin
      probe_b = 3'd2;
      arm(op, 4, 1, 0, 0);
      ticks(6); rd(1, "R7");
      probe_b = 3'd5; ticks(3); rd(1, "R7");
      probe_b = 3'd4; ticks(3); rd(1, "R7");
      probe_b = 3'd1; ticks(3); rd(1, "R7"); rd(6, "R7");
    end
    // R7 select 3 compares zero; select 0 and 2
    probe_b = 3'd0;
    arm(8, 0, 3, 0, 0); ticks(4); rd(1, "R7");
    arm(4, 200, 2, 0, 0); ticks(80); rd(1, "R7"); rd(6, "R7");
    arm(1, 0, 0, 0, 0); ticks(6); rd(1, "R7");

    // R10 immediate mode with maximum pre-trigger count (one post sample)
    arm(0, 0, 1, 1023, 1);
    ticks(1030);
    rd(1, "R10"); rd(6, "R10"); rd(7, "R10");
    rd(1024 + 5, "R12");

    // R8 full post window with immediate mode and count 10
    arm(0, 0, 1, 10, 1);
    ticks(500); rd(1, "R8");
    ticks(600); rd(1, "R8"); rd(6, "R9"); rd(7, "R9");

    ticks(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule